// File: doc/BRIEF.md
# Port Input Change Interrupt

This block raises the interrupt request of a 16-bit port expander whenever a pin configured as an input differs from the level the bus host last saw for it. Each 8-bit port keeps its own snapshot of raw pin levels. A pin that changes and then returns to its snapshot level clears its own contribution, and no read is needed for that. A read of a port also clears that port's condition. The bus interface sends a per-port strobe when it captures the port byte for transmission. It sends a second strobe on the clock falling edge that ends the acknowledge bit of that byte. That second strobe moves the captured byte into the snapshot.

Each port runs a small state machine. `W_QUIET` means no input pin differs. `W_FLAGGED` means at least one input pin differs. `W_ARMED` means a read byte has been captured and is waiting for the end of its acknowledge bit. The transitions are:
- capture (any state to `W_ARMED`)
- flag (`W_QUIET` to `W_FLAGGED`)
- self-clear (`W_FLAGGED` to `W_QUIET`)
- commit (`W_ARMED` to `W_QUIET` or `W_FLAGGED`, chosen by comparing the pins against the new snapshot)

The registered OR of the two port flags drives a pull-low enable for the open-drain line.

Top module: `pin_change_irq`

## Requirements
- R1: When an input-configured pin (its `dir_cfg` bit is 1) takes a level different from its port snapshot, `irq_pull` goes to 1 on the second rising clock edge after the new level is presented.
- R2: A pin whose `dir_cfg` bit is 0 (output) never causes `irq_pull`, whatever its level.
- R3: When every input pin returns to its snapshot level, `irq_pull` returns to 0 without any read, again two edges later.
- R4: A `rd_cap[p]` pulse captures the pin byte of port p (port 0 is bits 7:0, port 1 is bits 15:8). The next `ack_fall` pulse loads that captured byte into port p's snapshot. That port's condition is then judged against the new snapshot, and `irq_pull` follows one edge after the `ack_fall` edge.
- R5: The two ports are independent. A read of port 0 leaves a change on port 1 asserted, and a read of port 1 leaves a change on port 0 asserted.
- R6: Changing a pin from output to input while its level differs from the snapshot raises `irq_pull`.
- R7: An `ack_fall` pulse that is not preceded by a `rd_cap` of that port leaves the snapshot and `irq_pull` unchanged. This covers bus traffic for other devices.
- R8: While `rst_n` is 0, each snapshot loads the current pin levels. As a result, `irq_pull` is 0 after reset even when the pins are not all equal.
- R9: The snapshot takes the level present at capture, not at `ack_fall`. A pin that changes after capture keeps `irq_pull` at 1 after the commit, including when it changes in the same cycle as `ack_fall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | 16 | Synchronised raw pin levels |
| dir_cfg | input | 16 | Direction per pin, 1 = input, 0 = output |
| rd_cap | input | 2 | Per-port strobe: port byte captured for a read |
| ack_fall | input | 1 | Strobe: clock falling edge ending a read acknowledge bit |
| irq_pull | output | 1 | 1 = pull the interrupt line low |

## Verification
A snapshot commit and a pin change can fall in the same cycle. The bench provokes this by driving a new pin level in the very cycle that carries `ack_fall` for an armed read. It expects the interrupt to stay at 1, because the snapshot takes the byte held at capture and the live pin now differs from it. A plain change between capture and commit is judged the same way. The expected level is always computed from a bench model of the snapshots and the direction mask.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
    typedef enum logic [1:0] {
        W_QUIET   = 2'd0,
        W_FLAGGED = 2'd1,
        W_ARMED   = 2'd2
    } watch_st_e;
endpackage

// File: rtl/port_watch.sv
module port_watch
    import pcirq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] dir_i,
    input  logic         rd_cap_i,
    input  logic         ack_fall_i,
    output logic         flag_o
);
    watch_st_e    st_q, st_d;
    logic [W-1:0] snap_q, snap_d, hold_q;
    logic         commit, diff_d, flag_q;

    // Commit loads the byte captured for the read, not the live pins.
    assign commit = (st_q == W_ARMED) && ack_fall_i;
    assign snap_d = commit ? hold_q : snap_q;
    assign diff_d = |((pin_i ^ snap_d) & dir_i);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            W_QUIET:   st_d = diff_d ? W_FLAGGED : W_QUIET;
            W_FLAGGED: st_d = diff_d ? W_FLAGGED : W_QUIET;
            W_ARMED:   st_d = ack_fall_i ? (diff_d ? W_FLAGGED : W_QUIET) : W_ARMED;
            default:   st_d = W_QUIET;
        endcase
        if (rd_cap_i) st_d = W_ARMED;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= W_QUIET;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= pin_i;
            hold_q <= pin_i;
            flag_q <= 1'b0;
        end else begin
            snap_q <= snap_d;
            if (rd_cap_i) hold_q <= pin_i;
            flag_q <= diff_d;
        end
    end

    always_comb flag_o = flag_q;

    // R4: commit copies the captured byte into the snapshot
    p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q == W_ARMED && ack_fall_i && rst_n) |-> snap_q == $past(hold_q));
    // R4: a capture strobe arms the port
    p_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cap_i |=> st_q == W_ARMED);
    // R7: an unarmed acknowledge edge leaves the snapshot alone
    p_no_stray_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fall_i && st_q != W_ARMED) |=> $stable(snap_q));
    // R2: with every pin an output, the port flag stays low
    p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dir_i) == {W{1'b0}}) |-> !flag_q);
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags_i,
    output logic         irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |flags_i;
    end

    assign irq_o = irq_q;

    // R5: the line rises only when some port flag was set
    p_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|flags_i));
    // R3: the line falls only when every port flag was clear
    p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> !$past(|flags_i));
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
    parameter int PORT_W  = 8,
    parameter int N_PORTS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PORT_W*N_PORTS-1:0]   pin_lvl,
    input  logic [PORT_W*N_PORTS-1:0]   dir_cfg,
    input  logic [N_PORTS-1:0]          rd_cap,
    input  logic                        ack_fall,
    output logic                        irq_pull
);
    localparam int PIN_W = PORT_W * N_PORTS;

    logic [N_PORTS-1:0] port_flag;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        port_watch #(.W(PORT_W)) u_watch (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_i     (pin_lvl[p*PORT_W +: PORT_W]),
            .dir_i     (dir_cfg[p*PORT_W +: PORT_W]),
            .rd_cap_i  (rd_cap[p]),
            .ack_fall_i(ack_fall),
            .flag_o    (port_flag[p])
        );
    end

    irq_merge #(.N(N_PORTS)) u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .flags_i(port_flag),
        .irq_o  (irq_pull)
    );

    // R8: the first cycle out of reset has the line released
    p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_pull);
    // R2: outputs everywhere for two cycles keep the line released
    p_all_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dir_cfg, 2) == {PIN_W{1'b0}} && $past(dir_cfg) == {PIN_W{1'b0}}
         && $past(rst_n, 2)) |-> !irq_pull);
endmodule

// File: tb/pin_change_irq_tb_top.sv
module pin_change_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_lvl = 16'hA5C3;
    logic [15:0] dir_cfg = 16'hFFFF;
    logic [1:0]  rd_cap = 2'b00;
    logic        ack_fall = 1'b0;
    logic        irq_pull;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] snap_m [2];
    logic [7:0] hold_m [2];
    bit         armed_m [2];

    always #2 clk = ~clk;

    pin_change_irq dut_i (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .dir_cfg(dir_cfg),
        .rd_cap(rd_cap), .ack_fall(ack_fall), .irq_pull(irq_pull)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic exp);
        n_chk++;
        if (irq_pull !== exp) begin
            n_bad++;
            $display("FAIL %s irq_pull actual=%b expected=%b", tag, irq_pull, exp);
        end
    endtask

    function automatic logic exp_irq();
        logic [15:0] s;
        s = {snap_m[1], snap_m[0]};
        return |((pin_lvl ^ s) & dir_cfg);
    endfunction

    task automatic set_pins(input logic [15:0] v);
        pin_lvl = v;
        step(2);
    endtask

    task automatic capture(input int p);
        rd_cap[p] = 1'b1;
        hold_m[p] = pin_lvl[p*8 +: 8];
        armed_m[p] = 1;
        step(1);
        rd_cap = 2'b00;
    endtask

    task automatic ack_edge();
        ack_fall = 1'b1;
        for (int p = 0; p < 2; p++)
            if (armed_m[p]) begin
                snap_m[p] = hold_m[p];
                armed_m[p] = 0;
            end
        step(1);
        ack_fall = 1'b0;
        step(1);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] base;
        step(3);
        snap_m[0] = 8'hC3; snap_m[1] = 8'hA5;
        armed_m[0] = 0; armed_m[1] = 0;
        rst_n = 1'b1;
        step(2);
        chk("R8 reset with uneven pins", 1'b0);
        base = pin_lvl;

        // R1 / R3: every input pin toggled and restored
        for (int b = 0; b < 16; b++) begin
            set_pins(base ^ (16'h1 << b));
            chk($sformatf("R1 bit %0d change", b), exp_irq());
            set_pins(base);
            chk($sformatf("R3 bit %0d return", b), exp_irq());
        end

        // R2: all outputs, every pin toggled
        dir_cfg = 16'h0000;
        for (int b = 0; b < 16; b++) begin
            set_pins(base ^ (16'h1 << b));
            chk($sformatf("R2 bit %0d output masked", b), 1'b0);
        end
        // R2: mixed direction, toggles only on output pins
        dir_cfg = 16'h0F0F;
        set_pins(base ^ 16'hF0F0);
        chk("R2 mixed mask", 1'b0);

        // R6: output to input with differing levels
        dir_cfg = 16'hFFFF;
        step(2);
        chk("R6 output to input", exp_irq());

        // R5: reading one port leaves the other asserted
        capture(0);
        ack_edge();
        chk("R5 port1 still set after port0 read", exp_irq());
        capture(1);
        ack_edge();
        chk("R4 cleared after port1 read", exp_irq());
        base = pin_lvl;

        // R5 reverse direction
        set_pins(base ^ 16'h0010);
        capture(1);
        ack_edge();
        chk("R5 port0 still set after port1 read", exp_irq());

        // R7: stray acknowledge edge, no capture
        ack_fall = 1'b1; step(1); ack_fall = 1'b0; step(1);
        chk("R7 stray ack keeps irq", 1'b1);
        set_pins(base);
        chk("R7 snapshot unchanged, self clear", exp_irq());

        // R9: change between capture and commit
        set_pins(base ^ 16'h0200);
        capture(1);
        pin_lvl = base;
        step(1);
        ack_edge();
        chk("R9 change after capture keeps irq", exp_irq());
        capture(1);
        ack_edge();
        chk("R4 second read clears", exp_irq());

        // R9: pin change in the same cycle as the commit
        set_pins(base ^ 16'h0001);
        capture(0);
        pin_lvl = base ^ 16'h0003;
        ack_edge();
        chk("R9 same-cycle change with commit", exp_irq());
        capture(0);
        ack_edge();
        chk("R4 read after same-cycle case", exp_irq());

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule